// File: doc/BRIEF.md
# Shader Configuration Register Upload Unit

This block is the register front end for two programmable shader units, one for geometry and one for vertex work. It accepts register writes, each made of a word index, a 32-bit value and a 32-bit bit mask. Every write merges into the stored word bit by bit. Each unit owns a bank of 48 words. Both banks share one layout and differ only in where they sit in the index space.

A small set of bank words have side effects. The boolean and integer uniform words are copied into per-unit uniform state. Eight aliased data ports feed each of two per-unit memories, program code and swizzle patterns. Each port write stores its merged value at a running pointer and then steps that pointer. Software may also move a pointer by writing it directly.

A combinational read port gives the testbench a view of the plain registers, both memories of either unit and the uniform state.

Top module: `shader_cfg_upload`

## Requirements
- R1: Every accepted write stores (old & ~mask) | (value & mask), and any side effect uses that merged word.
- R2: The geometry bank occupies indices 0x280 to 0x2AF and the vertex bank occupies 0x2B0 to 0x2DF. Both banks use identical offsets, and a write to one bank never alters the other unit's state.
- R3: A write to bank offset 0x00 loads boolean uniform i from merged bit i, for i from 0 to 15.
- R4: A write to bank offset k, with k from 1 to 4, loads integer uniform k-1 with lanes x, y, z and w taken from merged bits 7:0, 15:8, 23:16 and 31:24.
- R5: A write to any of the program ports at bank offsets 0x1C to 0x23 stores the merged word into program memory at the program pointer, then increments that pointer.
- R6: A write to any of the swizzle ports at bank offsets 0x26 to 0x2D stores the merged word into swizzle memory at the swizzle pointer, then increments that pointer.
- R7: The program pointer sits at bank offset 0x1B and the swizzle pointer at 0x25. A write there loads merged bits 9:0. A register read there returns the pointer zero-extended. Incrementing past 1023 wraps to 0. Each pointer holds its value when no write reaches it.
- R8: A port write with mask zero still advances the pointer and stores the port word's previous contents into memory.
- R9: Words without side effects are plain storage that reads back the merged value. Examples are the entry offset at 0x0A, the input map at 0x0B and 0x0C, the uniform setup word at 0x10, and indices outside both banks.
- R10: Writes at index 0x300 or above change nothing, and register reads there return 0.
- R11: After reset all registers, pointers and uniforms read as zero.
- R12: The read space select works as follows: 0 reads a register at rd_idx_i, 1 reads program memory and 2 reads swizzle memory of unit rd_unit_i (0 is geometry) at rd_idx_i[9:0]. A select of 3 reads uniforms, where index 0 gives the booleans in bits 15:0, indices 1 to 4 give integer uniforms 0 to 3 as {w,z,y,x}, and any other index gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_idx_i | input | 10 | Register word index |
| wr_data_i | input | 32 | Write value |
| wr_mask_i | input | 32 | Per-bit write mask |
| rd_space_i | input | 2 | Read space select |
| rd_unit_i | input | 1 | Unit for memory and uniform reads (0 geometry, 1 vertex) |
| rd_idx_i | input | 10 | Read index or memory address |
| rd_data_o | output | 32 | Read data, combinational |

## Verification
A pointer that skips, stalls or fails to wrap misplaces every later upload word. The memory sweep exposes this on the first read after the faulty write, because each address holds a value unique to its unit, memory and position. A wrong merge or decode shows on the read that immediately follows the write. Crossed bank decoding shows up as a uniform or memory word of one unit changing when the other unit is written.

// File: rtl/shcfg_pkg.sv
package shcfg_pkg;
  localparam int BANK_WORDS = 48;
  localparam logic [5:0] OFF_BOOL     = 6'h00;
  localparam logic [5:0] OFF_INT0     = 6'h01;
  localparam logic [5:0] OFF_PROG_PTR = 6'h1B;
  localparam logic [5:0] OFF_PROG_P0  = 6'h1C;
  localparam logic [5:0] OFF_SWZ_PTR  = 6'h25;
  localparam logic [5:0] OFF_SWZ_P0   = 6'h26;
  localparam logic [5:0] NUM_PORTS    = 6'd8;
  localparam int NUM_INTS = 4;

  typedef enum logic [1:0] {
    SPACE_REG  = 2'd0,
    SPACE_PROG = 2'd1,
    SPACE_SWZ  = 2'd2,
    SPACE_UNI  = 2'd3
  } rd_space_e;
endpackage

// File: rtl/shcfg_regstore.sv
module shcfg_regstore #(
  parameter int WORDS = 768,
  parameter int IDX_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] widx_i,
  input  logic [31:0]      wdata_i,
  input  logic [IDX_W-1:0] ridx_a_i,
  output logic [31:0]      rdata_a_o,
  input  logic [IDX_W-1:0] ridx_b_i,
  output logic [31:0]      rdata_b_o
);
  logic [31:0] store_q [WORDS];

  function automatic logic in_range(input logic [IDX_W-1:0] idx);
    return ({1'b0, idx} < (IDX_W+1)'(WORDS));
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < WORDS; i++) store_q[i] <= '0;
    end else if (we_i && in_range(widx_i)) begin
      store_q[widx_i] <= wdata_i;
    end
  end

  assign rdata_a_o = in_range(ridx_a_i) ? store_q[ridx_a_i] : '0;
  assign rdata_b_o = in_range(ridx_b_i) ? store_q[ridx_b_i] : '0;
endmodule

// File: rtl/shcfg_mem.sv
module shcfg_mem #(
  parameter int DEPTH = 1024,
  parameter int AW    = $clog2(DEPTH),
  parameter int DW    = 32
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/shcfg_unit.sv
module shcfg_unit
  import shcfg_pkg::*;
#(
  parameter int MEM_DEPTH = 1024,
  parameter int PTR_W     = $clog2(MEM_DEPTH)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [5:0]           off_i,
  input  logic [31:0]          val_i,
  input  logic                 rd_swz_i,
  input  logic [PTR_W-1:0]     rd_addr_i,
  output logic [31:0]          mem_rdata_o,
  output logic [PTR_W-1:0]     prog_ptr_o,
  output logic [PTR_W-1:0]     swz_ptr_o,
  output logic [15:0]          bools_o,
  output logic [NUM_INTS-1:0][31:0] ints_o
);
  logic prog_port, swz_port, prog_ld, swz_ld, bool_ld;
  logic [PTR_W-1:0] prog_ptr_q, swz_ptr_q;
  logic [31:0] prog_rdata, swz_rdata;

  always_comb begin
    prog_port = we_i && (off_i >= OFF_PROG_P0) && (off_i < OFF_PROG_P0 + NUM_PORTS);
    swz_port  = we_i && (off_i >= OFF_SWZ_P0) && (off_i < OFF_SWZ_P0 + NUM_PORTS);
    prog_ld   = we_i && (off_i == OFF_PROG_PTR);
    swz_ld    = we_i && (off_i == OFF_SWZ_PTR);
    bool_ld   = we_i && (off_i == OFF_BOOL);
  end

  // pointers wrap naturally: MEM_DEPTH is a power of two
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prog_ptr_q <= '0;
      swz_ptr_q  <= '0;
      bools_o    <= '0;
    end else begin
      if (prog_ld)        prog_ptr_q <= val_i[PTR_W-1:0];
      else if (prog_port) prog_ptr_q <= prog_ptr_q + 1'b1;
      if (swz_ld)         swz_ptr_q  <= val_i[PTR_W-1:0];
      else if (swz_port)  swz_ptr_q  <= swz_ptr_q + 1'b1;
      if (bool_ld)        bools_o    <= val_i[15:0];
    end
  end

  for (genvar k = 0; k < NUM_INTS; k++) begin : g_int
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ints_o[k] <= '0;
      else if (we_i && off_i == OFF_INT0 + 6'(k)) ints_o[k] <= val_i;
    end
  end

  shcfg_mem #(.DEPTH(MEM_DEPTH), .AW(PTR_W), .DW(32)) u_prog (
    .clk_i(clk_i), .we_i(prog_port), .waddr_i(prog_ptr_q), .wdata_i(val_i),
    .raddr_i(rd_addr_i), .rdata_o(prog_rdata)
  );

  shcfg_mem #(.DEPTH(MEM_DEPTH), .AW(PTR_W), .DW(32)) u_swz (
    .clk_i(clk_i), .we_i(swz_port), .waddr_i(swz_ptr_q), .wdata_i(val_i),
    .raddr_i(rd_addr_i), .rdata_o(swz_rdata)
  );

  assign mem_rdata_o = rd_swz_i ? swz_rdata : prog_rdata;
  assign prog_ptr_o  = prog_ptr_q;
  assign swz_ptr_o   = swz_ptr_q;
endmodule

// File: rtl/shader_cfg_upload.sv
module shader_cfg_upload
  import shcfg_pkg::*;
#(
  parameter int IDX_W     = 10,
  parameter int REG_WORDS = 768,
  parameter logic [IDX_W-1:0] GEO_BASE = 10'h280,
  parameter logic [IDX_W-1:0] VTX_BASE = 10'h2B0,
  parameter int MEM_DEPTH = 1024
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [31:0]      wr_data_i,
  input  logic [31:0]      wr_mask_i,
  input  logic [1:0]       rd_space_i,
  input  logic             rd_unit_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [31:0]      rd_data_o
);
  localparam int PTR_W     = $clog2(MEM_DEPTH);
  localparam int NUM_UNITS = 2;
  localparam logic [NUM_UNITS-1:0][IDX_W-1:0] BASES = {VTX_BASE, GEO_BASE};

  logic [NUM_UNITS-1:0] wr_hit, rd_hit;
  logic [5:0]           wr_off [NUM_UNITS];
  logic [5:0]           rd_off [NUM_UNITS];
  logic [PTR_W-1:0]     prog_ptr [NUM_UNITS];
  logic [PTR_W-1:0]     swz_ptr [NUM_UNITS];
  logic [15:0]          bools_u [NUM_UNITS];
  logic [NUM_INTS-1:0][31:0] ints_u [NUM_UNITS];
  logic [31:0]          mem_rd [NUM_UNITS];
  logic [31:0]          store_old, store_rd, old_word, merged;
  rd_space_e            space;
  logic [IDX_W-1:0]     int_sel;

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    logic [IDX_W-1:0] wdiff, rdiff;
    assign wdiff     = wr_idx_i - BASES[u];
    assign rdiff     = rd_idx_i - BASES[u];
    assign wr_hit[u] = ({1'b0, wr_idx_i} >= {1'b0, BASES[u]}) &&
                       ({1'b0, wr_idx_i} <  {1'b0, BASES[u]} + (IDX_W+1)'(BANK_WORDS));
    assign rd_hit[u] = ({1'b0, rd_idx_i} >= {1'b0, BASES[u]}) &&
                       ({1'b0, rd_idx_i} <  {1'b0, BASES[u]} + (IDX_W+1)'(BANK_WORDS));
    assign wr_off[u] = wdiff[5:0];
    assign rd_off[u] = rdiff[5:0];

    shcfg_unit #(.MEM_DEPTH(MEM_DEPTH), .PTR_W(PTR_W)) u_unit (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .we_i       (wr_en_i && wr_hit[u]),
      .off_i      (wr_off[u]),
      .val_i      (merged),
      .rd_swz_i   (space == SPACE_SWZ),
      .rd_addr_i  (PTR_W'(rd_idx_i)),
      .mem_rdata_o(mem_rd[u]),
      .prog_ptr_o (prog_ptr[u]),
      .swz_ptr_o  (swz_ptr[u]),
      .bools_o    (bools_u[u]),
      .ints_o     (ints_u[u])
    );
  end

  shcfg_regstore #(.WORDS(REG_WORDS), .IDX_W(IDX_W)) u_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (wr_en_i),
    .widx_i   (wr_idx_i),
    .wdata_i  (merged),
    .ridx_a_i (wr_idx_i),
    .rdata_a_o(store_old),
    .ridx_b_i (rd_idx_i),
    .rdata_b_o(store_rd)
  );

  // pointer words live in the units; everything else in plain storage
  always_comb begin
    old_word = store_old;
    for (int u = 0; u < NUM_UNITS; u++) begin
      if (wr_hit[u] && wr_off[u] == OFF_PROG_PTR) old_word = 32'(prog_ptr[u]);
      if (wr_hit[u] && wr_off[u] == OFF_SWZ_PTR)  old_word = 32'(swz_ptr[u]);
    end
    merged = (old_word & ~wr_mask_i) | (wr_data_i & wr_mask_i);
  end

  assign space   = rd_space_e'(rd_space_i);
  assign int_sel = rd_idx_i - 1'b1;

  always_comb begin
    rd_data_o = '0;
    unique case (space)
      SPACE_REG: begin
        rd_data_o = store_rd;
        for (int u = 0; u < NUM_UNITS; u++) begin
          if (rd_hit[u] && rd_off[u] == OFF_PROG_PTR) rd_data_o = 32'(prog_ptr[u]);
          if (rd_hit[u] && rd_off[u] == OFF_SWZ_PTR)  rd_data_o = 32'(swz_ptr[u]);
        end
      end
      SPACE_PROG, SPACE_SWZ: rd_data_o = mem_rd[rd_unit_i];
      SPACE_UNI: begin
        if (rd_idx_i == '0)
          rd_data_o = {16'h0, bools_u[rd_unit_i]};
        else if (rd_idx_i <= IDX_W'(NUM_INTS))
          rd_data_o = ints_u[rd_unit_i][int_sel[1:0]];
      end
      default: rd_data_o = '0;
    endcase
  end
endmodule

// File: rtl/shcfg_upload_chk.sv
module shcfg_upload_chk #(
  parameter int IDX_W     = 10,
  parameter int PTR_W     = 10,
  parameter int REG_WORDS = 768,
  parameter logic [IDX_W-1:0] GEO_BASE = 10'h280,
  parameter logic [IDX_W-1:0] VTX_BASE = 10'h2B0
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic [IDX_W-1:0] wr_idx_i,
  input logic [31:0]      wr_data_i,
  input logic [31:0]      wr_mask_i,
  input logic [PTR_W-1:0] geo_prog_ptr,
  input logic [PTR_W-1:0] vtx_swz_ptr,
  input logic [15:0]      geo_bools,
  input logic [15:0]      vtx_bools
);
  logic geo_prog_port, vtx_swz_port, vtx_bool_full, oob;

  assign geo_prog_port = wr_en_i && (wr_idx_i >= GEO_BASE + IDX_W'(8'h1C)) &&
                         (wr_idx_i <= GEO_BASE + IDX_W'(8'h23));
  assign vtx_swz_port  = wr_en_i && (wr_idx_i >= VTX_BASE + IDX_W'(8'h26)) &&
                         (wr_idx_i <= VTX_BASE + IDX_W'(8'h2D));
  assign vtx_bool_full = wr_en_i && (wr_idx_i == VTX_BASE) && (wr_mask_i[15:0] == 16'hFFFF);
  assign oob           = wr_en_i && ({1'b0, wr_idx_i} >= (IDX_W+1)'(REG_WORDS));

  assert_prog_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    geo_prog_port |=> geo_prog_ptr == $past(geo_prog_ptr) + 1'b1);

  assert_swz_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vtx_swz_port |=> vtx_swz_ptr == $past(vtx_swz_ptr) + 1'b1);

  assert_bool_load_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vtx_bool_full |=> vtx_bools == $past(wr_data_i[15:0]));

  assert_oob_ignored_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oob |=> $stable(geo_prog_ptr) && $stable(vtx_swz_ptr) && $stable(geo_bools) && $stable(vtx_bools));

  assert_ptr_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(geo_prog_ptr) && $stable(vtx_swz_ptr));
endmodule

bind shader_cfg_upload shcfg_upload_chk #(
  .IDX_W(IDX_W), .PTR_W(PTR_W), .REG_WORDS(REG_WORDS),
  .GEO_BASE(GEO_BASE), .VTX_BASE(VTX_BASE)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_en_i     (wr_en_i),
  .wr_idx_i    (wr_idx_i),
  .wr_data_i   (wr_data_i),
  .wr_mask_i   (wr_mask_i),
  .geo_prog_ptr(prog_ptr[0]),
  .vtx_swz_ptr (swz_ptr[1]),
  .geo_bools   (bools_u[0]),
  .vtx_bools   (bools_u[1])
);

// File: tb/shader_cfg_upload_bench.sv
module shader_cfg_upload_bench;
  localparam int DEPTH = 1024;
  localparam logic [9:0] GEO = 10'h280;
  localparam logic [9:0] VTX = 10'h2B0;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic wr_en = 1'b0;
  logic [9:0] wr_idx = '0;
  logic [31:0] wr_data = '0, wr_mask = '0;
  logic [1:0] rd_space = '0;
  logic rd_unit = 1'b0;
  logic [9:0] rd_idx = '0;
  logic [31:0] rd_data;
  int n_chk = 0, n_bad = 0;
  bit timed_out = 1'b0;

  always #5 clk = ~clk;

  shader_cfg_upload u_shader_cfg_upload (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_idx_i(wr_idx),
    .wr_data_i(wr_data), .wr_mask_i(wr_mask), .rd_space_i(rd_space),
    .rd_unit_i(rd_unit), .rd_idx_i(rd_idx), .rd_data_o(rd_data)
  );

  function automatic logic [9:0] base_of(input int u);
    return (u == 0) ? GEO : VTX;
  endfunction

  function automatic logic [31:0] pat(input int u, input int sel, input int i);
    return (32'(i + 1) * 32'h9E3779B9) ^ (32'(u) << 31) ^ (32'(sel) << 30);
  endfunction

  task automatic wr(input logic [9:0] idx, input logic [31:0] d, input logic [31:0] m);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = idx; wr_data = d; wr_mask = m;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sp, input int u, input logic [9:0] a, output logic [31:0] d);
    rd_space = sp; rd_unit = u[0]; rd_idx = a;
    #1;
    d = rd_data;
  endtask

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic run_all();
    logic [31:0] d;
    logic [31:0] a0, a1;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R11 reset state
    rd(2'd0, 0, 10'h000, d); chk("R11 reg0", d, 0);
    rd(2'd0, 0, GEO + 10'h1B, d); chk("R11 geo prog ptr", d, 0);
    rd(2'd0, 0, VTX + 10'h25, d); chk("R11 vtx swz ptr", d, 0);
    for (int u = 0; u < 2; u++) begin
      rd(2'd3, u, 10'd0, d); chk("R11 bools", d, 0);
      rd(2'd3, u, 10'd3, d); chk("R11 int2", d, 0);
    end

    // R1 masked merge on plain storage
    wr(10'h200, 32'hFFFF_0000, 32'hFFFF_FFFF);
    wr(10'h200, 32'h0000_1234, 32'h0000_FFFF);
    rd(2'd0, 0, 10'h200, d); chk("R1 low half merge", d, 32'hFFFF_1234);
    wr(10'h200, 32'h0000_0000, 32'hFF00_0000);
    rd(2'd0, 0, 10'h200, d); chk("R1 top byte clear", d, 32'h00FF_1234);

    // R9 plain bank words
    wr(GEO + 10'h0A, 32'h1234_ABCD, 32'hFFFF_FFFF);
    rd(2'd0, 0, GEO + 10'h0A, d); chk("R9 entry offset", d, 32'h1234_ABCD);
    wr(VTX + 10'h0B, 32'hFEDC_BA98, 32'hFFFF_FFFF);
    wr(VTX + 10'h0C, 32'h7654_3210, 32'hFFFF_FFFF);
    rd(2'd0, 0, VTX + 10'h0B, d); chk("R9 map lo", d, 32'hFEDC_BA98);
    rd(2'd0, 0, VTX + 10'h0C, d); chk("R9 map hi", d, 32'h7654_3210);
    wr(VTX + 10'h10, 32'h8000_007F, 32'hFFFF_FFFF);
    rd(2'd0, 0, VTX + 10'h10, d); chk("R9 setup word", d, 32'h8000_007F);

    // R3 walking boolean bits, both units
    for (int u = 0; u < 2; u++) begin
      for (int i = 0; i < 16; i++) begin
        wr(base_of(u), 32'h1 << i, 32'hFFFF_FFFF);
        rd(2'd3, u, 10'd0, d); chk("R3 bool walk", d, 32'h1 << i);
      end
      wr(base_of(u), 32'h0, 32'hFFFF_FFFF);
      wr(base_of(u), 32'hFFFF_FFFF, 32'h0000_00F0);
      rd(2'd3, u, 10'd0, d); chk("R3 R1 masked bools", d, 32'h0000_00F0);
    end

    // R4 integer uniforms; R2 isolation across banks
    for (int u = 0; u < 2; u++)
      for (int k = 1; k <= 4; k++)
        wr(base_of(u) + 10'(k), pat(u, 2, k), 32'hFFFF_FFFF);
    for (int u = 0; u < 2; u++)
      for (int k = 1; k <= 4; k++) begin
        rd(2'd3, u, 10'(k), d); chk("R4 R2 int uniform", d, pat(u, 2, k));
      end
    wr(GEO + 10'h2, 32'h4433_2211, 32'h00FF_00FF);
    rd(2'd3, 0, 10'd2, d);
    chk("R4 lane merge", d, (pat(0, 2, 2) & 32'hFF00_FF00) | 32'h0033_0011);
    rd(2'd3, 0, 10'd5, d); chk("R12 uniform idx out of range", d, 0);
    rd(2'd3, 1, 10'd0, d); chk("R2 vtx bools untouched", d, 32'h0000_00F0);

    // R5 R6 full sweeps over all ports, then wrap to 0
    for (int u = 0; u < 2; u++)
      for (int s = 0; s < 2; s++) begin
        wr(base_of(u) + (s == 0 ? 10'h1B : 10'h25), 32'h0, 32'hFFFF_FFFF);
        for (int i = 0; i < DEPTH; i++)
          wr(base_of(u) + (s == 0 ? 10'h1C : 10'h26) + 10'(i % 8), pat(u, s, i), 32'hFFFF_FFFF);
        rd(2'd0, 0, base_of(u) + (s == 0 ? 10'h1B : 10'h25), d);
        chk("R7 ptr wrapped after full sweep", d, 0);
      end
    for (int u = 0; u < 2; u++)
      for (int s = 0; s < 2; s++)
        for (int i = 0; i < DEPTH; i++) begin
          rd(s == 0 ? 2'd1 : 2'd2, u, 10'(i), d);
          chk(s == 0 ? "R5 program word" : "R6 swizzle word", d, pat(u, s, i));
        end

    // R7 explicit wrap: 1022, 1023, 0
    wr(GEO + 10'h1B, 32'd1022, 32'hFFFF_FFFF);
    for (int i = 0; i < 3; i++) wr(GEO + 10'h23, 32'hC0DE_0000 + 32'(i), 32'hFFFF_FFFF);
    rd(2'd1, 0, 10'd1022, d); chk("R7 wrap 1022", d, 32'hC0DE_0000);
    rd(2'd1, 0, 10'd1023, d); chk("R7 wrap 1023", d, 32'hC0DE_0001);
    rd(2'd1, 0, 10'd0, d);    chk("R7 wrap 0", d, 32'hC0DE_0002);
    rd(2'd0, 0, GEO + 10'h1B, d); chk("R7 ptr after wrap", d, 1);
    rd(2'd1, 1, 10'd0, d); chk("R2 vtx program untouched", d, pat(1, 0, 0));

    // R8 zero-mask port write, then partial mask
    wr(VTX + 10'h1B, 32'd5, 32'hFFFF_FFFF);
    wr(VTX + 10'h1D, 32'hCAFE_0001, 32'hFFFF_FFFF);
    wr(VTX + 10'h1D, 32'h1234_5678, 32'h0000_0000);
    wr(VTX + 10'h1D, 32'h1111_2222, 32'h0000_FFFF);
    rd(2'd1, 1, 10'd5, d); chk("R5 direct write", d, 32'hCAFE_0001);
    rd(2'd1, 1, 10'd6, d); chk("R8 zero mask stores old", d, 32'hCAFE_0001);
    rd(2'd1, 1, 10'd7, d); chk("R8 R1 partial mask", d, 32'hCAFE_2222);
    rd(2'd0, 0, VTX + 10'h1D, d); chk("R1 port word stored", d, 32'hCAFE_2222);
    rd(2'd0, 0, VTX + 10'h1B, d); chk("R8 ptr advanced", d, 8);

    // R7 masked pointer write: (8 & ~0xF) | (0x3FF & 0xF)
    wr(VTX + 10'h1B, 32'h3FF, 32'h0000_000F);
    rd(2'd0, 0, VTX + 10'h1B, d); chk("R7 R1 masked ptr", d, 32'h0F);

    // R10 out-of-range index
    rd(2'd1, 0, 10'd1, a0);
    wr(10'h300, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    wr(10'h3FF, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    rd(2'd0, 0, 10'h300, d); chk("R10 read 0x300", d, 0);
    rd(2'd0, 0, 10'h3FF, d); chk("R10 read 0x3FF", d, 0);
    rd(2'd0, 0, GEO + 10'h1B, d); chk("R10 geo ptr held", d, 1);
    rd(2'd3, 0, 10'd0, d); chk("R10 geo bools held", d, 32'h0000_00F0);
    wr(GEO + 10'h1C, 32'hAAAA_5555, 32'hFFFF_FFFF);
    rd(2'd1, 0, 10'd1, a1); chk("R5 resumes at 1", a1, 32'hAAAA_5555);
    chk("R5 slot changed", 32'(a0 != a1), 1);
    // R9 index outside banks below geometry base
    wr(10'h27F, 32'h0BAD_F00D, 32'hFFFF_FFFF);
    rd(2'd0, 0, 10'h27F, d); chk("R9 outside banks", d, 32'h0BAD_F00D);
    rd(2'd3, 0, 10'd0, d); chk("R2 below base no bool load", d, 32'h0000_00F0);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        timed_out = 1'b1;
      end
    join_any
    if (timed_out) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog got=%h exp=%h", 32'd1, 32'd0);
    end
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule